// File: doc/BRIEF.md
# Conversion Mode and Calibration Sequencer

This block is the control engine that sits between a host-written 3-bit mode field and an abstracted modulator/filter pair. For each mode it decides whether the filter runs or is held in reset, counts conversion periods at the selected output rate, and accepts the filtered result. It then updates the data register, the ready and error flags, or writes a measured or stored calibration coefficient into the offset or full-scale slot of the current channel. Calibration and single-shot modes fall back on their own to idle or power-down when they finish.

The filter result arrives on a valid/ready stream. `res_ready_o` is high only while a result is due, meaning the required number of conversion periods has elapsed. A transfer takes place on a clock edge where `res_valid_i` and `res_ready_o` are both high. The filter must hold `res_valid_i`, `res_data_i` and `res_clamp_i` steady until that transfer. While a result is due, the period counter waits, so a slow filter stretches the period instead of losing data. A valid presented while `res_ready_o` is low is ignored. Control and status pins are plain levels or one-cycle strobes.

A conversion period lasts `(code+1)*BASE_CNT` clock cycles, where code is the 4-bit rate code. The defaults are `BASE_CNT`=8 and `GUARD`=2. The rate is sampled only when a conversion restarts.

Top module: `conv_cal_seq`

## Requirements
- R1: Mode codes are 0 continuous, 1 single, 2 idle, 3 power-down, 4 internal offset calibration, 5 internal gain calibration, 6 system offset calibration, 7 system gain calibration. After reset the mode is continuous, `rdy_o`=1, `err_o`=0 and `data_o`=0. A result is due (`res_ready_o` high) two periods after reset release or after a mode write. Each accepted result loads `data_o` and drives `rdy_o` low. Later results are due one period after each transfer.
- R2: In continuous or single mode, a pulse on `cfg_wr_i` or a change of `chan_i` restarts the conversion. The restart pulses `conv_start_o` for one cycle and sets `rdy_o`. The next result is due two periods later.
- R3: In single mode the result is due after two periods. The transfer loads `data_o`, drives `rdy_o` low and moves the mode to power-down, where `rdy_o` stays low until a read.
- R4: A pulse on `rd_data_i` sets `rdy_o`.
- R5: In idle and power-down, `mod_rst_o`=1 and `res_ready_o` stays low. `pdown_o`=1 exactly in power-down. A write of any accepted mode sets `rdy_o`.
- R6: Modes 4, 6 and 7 take two periods. On the transfer, one strobe fires for one cycle: `coef_wr_off_o` for modes 4 and 6, or `coef_wr_fs_o` for mode 7. The strobe carries the result on `coef_data_o` and the channel on `coef_ch_o`. The mode becomes idle and `rdy_o` goes low.
- R7: Mode 5 takes four periods when `gain_one_i`=0 and two periods when `gain_one_i`=1 with `int_ref_i`=0. It ends as in R6 with `coef_wr_fs_o`.
- R8: Mode 5 with `gain_one_i`=1 and `int_ref_i`=1 measures nothing. `rdy_o` is high in the cycle after the write. In the next cycle `coef_wr_fs_o` fires with `FACTORY_FS`, the mode becomes idle and `rdy_o` goes low.
- R9: A write of mode 5 while `gain_max_i`=1 is ignored. The mode, `rdy_o` and the period counter are unchanged.
- R10: `err_o` takes `res_clamp_i` whenever `data_o` is loaded. It is cleared when a conversion or calibration starts.
- R11: In continuous mode, `rdy_o` rises exactly `GUARD` cycles before the next result is due.
- R12: A host coefficient write (`host_coef_wr_i`, with `host_coef_fs_i` 0 for offset and 1 for full-scale) produces the matching strobe one cycle later, but only in idle or power-down. In other modes it produces no strobe.
- R13: The period length is `(rate+1)*BASE_CNT` cycles. A change of `rate_i` takes effect only at the next restart.
- R14: A result is taken only on an edge where `res_valid_i` and `res_ready_o` are both high. A valid presented while no result is due leaves `data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Requested mode code |
| mode_wr_i | input | 1 | Mode write strobe |
| cfg_wr_i | input | 1 | Configuration/IO write strobe (restarts conversion) |
| chan_i | input | CH_W | Selected channel |
| rate_i | input | RATE_W | Output rate code |
| gain_one_i | input | 1 | Gain setting is 1 |
| gain_max_i | input | 1 | Gain setting is the maximum (internal gain calibration illegal) |
| int_ref_i | input | 1 | Internal reference selected |
| rd_data_i | input | 1 | Data register read strobe |
| res_valid_i | input | 1 | Filter result valid |
| res_ready_o | output | 1 | Result due and accepted |
| res_data_i | input | DATA_W | Filter result |
| res_clamp_i | input | 1 | Result was clamped by over/under-range |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| mod_rst_o | output | 1 | Hold modulator and filter in reset |
| pdown_o | output | 1 | Power-down mode active |
| mode_o | output | 3 | Current mode |
| data_o | output | DATA_W | Data register |
| rdy_o | output | 1 | Ready flag (high = do not read) |
| err_o | output | 1 | Clamp error flag |
| host_coef_wr_i | input | 1 | Host coefficient write strobe |
| host_coef_fs_i | input | 1 | Host write target: 0 offset, 1 full-scale |
| host_coef_ch_i | input | CH_W | Host write channel |
| host_coef_data_i | input | DATA_W | Host write value |
| coef_wr_off_o | output | 1 | Offset coefficient write strobe |
| coef_wr_fs_o | output | 1 | Full-scale coefficient write strobe |
| coef_ch_o | output | CH_W | Coefficient channel |
| coef_data_o | output | DATA_W | Coefficient value |

## Verification
The bench times every mode from its start to `res_ready_o`, which exposes a sequencer that miscounts periods or applies the four-period gain rule in the wrong case. It checks that ready rises `GUARD` cycles ahead of the result, and that a rate change waits for a restart; a design that reloads the period at once would deliver a short period. It also drives the gain-max internal calibration request and host coefficient writes outside idle. A design that takes either would change mode or emit a strobe. Finally, it leaves a single-shot result unread for many cycles, which catches power-down entry wrongly setting ready.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    M_CONT   = 3'd0,
    M_SINGLE = 3'd1,
    M_IDLE   = 3'd2,
    M_PDOWN  = 3'd3,
    M_ZS     = 3'd4,
    M_IFS    = 3'd5,
    M_SOFF   = 3'd6,
    M_SFS    = 3'd7
  } mode_e;

  function automatic int period_cycles(input int code, input int base);
    return (code + 1) * base;
  endfunction
endpackage

// File: rtl/seq_rate_timer.sv
module seq_rate_timer #(
  parameter int RATE_W   = 4,
  parameter int PERIOD_W = 16,
  parameter int BASE_CNT = 8,
  parameter int GUARD    = 2,
  parameter int RST_RATE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [2:0]        need_i,
  input  logic              res_valid_i,
  output logic              due_o,
  output logic              take_o,
  output logic              guard_o
);
  localparam logic [PERIOD_W-1:0] RST_LEN =
    PERIOD_W'(seq_pkg::period_cycles(RST_RATE, BASE_CNT));

  logic [PERIOD_W-1:0] len_q, cnt_q;
  logic [2:0]          left_q;
  logic                due_q;
  logic                last_cyc;

  assign last_cyc = (cnt_q == len_q - PERIOD_W'(1));
  assign due_o    = due_q & run_i;
  assign take_o   = due_o & res_valid_i & ~restart_i;
  assign guard_o  = run_i & ~due_q & (left_q == 3'd1) &
                    (cnt_q == len_q - PERIOD_W'(GUARD + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= RST_LEN;
      cnt_q  <= '0;
      left_q <= 3'd2;
      due_q  <= 1'b0;
    end else if (restart_i) begin
      len_q  <= PERIOD_W'(seq_pkg::period_cycles(int'(rate_i), BASE_CNT));
      cnt_q  <= '0;
      left_q <= need_i;
      due_q  <= 1'b0;
    end else if (take_o) begin
      cnt_q  <= '0;
      left_q <= 3'd1;
      due_q  <= 1'b0;
    end else if (run_i && !due_q) begin
      if (last_cyc) begin
        cnt_q <= '0;
        if (left_q <= 3'd1) due_q <= 1'b1;
        else                left_q <= left_q - 3'd1;
      end else begin
        cnt_q <= cnt_q + PERIOD_W'(1);
      end
    end
  end

  // a due result waits for the filter (R14)
  p_due_holds_r14: assert property (@(posedge clk) disable iff (!rst_n)
    due_q && run_i && !res_valid_i && !restart_i |=> due_q);

  // the rate is only sampled on restart (R13)
  p_len_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> $stable(len_q));
endmodule

// File: rtl/seq_coef_port.sv
module seq_coef_port #(
  parameter int DATA_W = 24,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow_i,
  input  logic              int_off_i,
  input  logic              int_fs_i,
  input  logic [CH_W-1:0]   int_ch_i,
  input  logic [DATA_W-1:0] int_data_i,
  input  logic              host_wr_i,
  input  logic              host_fs_i,
  input  logic [CH_W-1:0]   host_ch_i,
  input  logic [DATA_W-1:0] host_data_i,
  output logic              wr_off_o,
  output logic              wr_fs_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off_o <= 1'b0;
      wr_fs_o  <= 1'b0;
      ch_o     <= '0;
      data_o   <= '0;
    end else if (int_off_i || int_fs_i) begin
      wr_off_o <= int_off_i;
      wr_fs_o  <= int_fs_i;
      ch_o     <= int_ch_i;
      data_o   <= int_data_i;
    end else if (host_wr_i && allow_i) begin
      wr_off_o <= ~host_fs_i;
      wr_fs_o  <= host_fs_i;
      ch_o     <= host_ch_i;
      data_o   <= host_data_i;
    end else begin
      wr_off_o <= 1'b0;
      wr_fs_o  <= 1'b0;
    end
  end

  // host writes outside idle/power-down leave no strobe (R12)
  p_host_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_i && !allow_i && !int_off_i && !int_fs_i |=> !wr_off_o && !wr_fs_o);

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_off_o, wr_fs_o}));
endmodule

// File: rtl/conv_cal_seq.sv
module conv_cal_seq
  import seq_pkg::*;
#(
  parameter int                DATA_W     = 24,
  parameter int                CH_W       = 2,
  parameter int                RATE_W     = 4,
  parameter int                PERIOD_W   = 16,
  parameter int                BASE_CNT   = 8,
  parameter int                GUARD      = 2,
  parameter int                RST_RATE   = 1,
  parameter logic [DATA_W-1:0] FACTORY_FS = 24'h5A5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              mode_wr_i,
  input  logic              cfg_wr_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              gain_one_i,
  input  logic              gain_max_i,
  input  logic              int_ref_i,
  input  logic              rd_data_i,
  input  logic              res_valid_i,
  output logic              res_ready_o,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              res_clamp_i,
  output logic              conv_start_o,
  output logic              mod_rst_o,
  output logic              pdown_o,
  output logic [2:0]        mode_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              err_o,
  input  logic              host_coef_wr_i,
  input  logic              host_coef_fs_i,
  input  logic [CH_W-1:0]   host_coef_ch_i,
  input  logic [DATA_W-1:0] host_coef_data_i,
  output logic              coef_wr_off_o,
  output logic              coef_wr_fs_o,
  output logic [CH_W-1:0]   coef_ch_o,
  output logic [DATA_W-1:0] coef_data_o
);
  mode_e             mode_q;
  logic              running_q, rdy_q, err_q, fac_pend_q, start_q;
  logic [CH_W-1:0]   chan_q;
  logic [DATA_W-1:0] data_q;

  mode_e       req_mode;
  logic        illegal, mw_ok, factory, new_runs, conv_mode, re_conv, restart;
  logic [2:0]  need;
  logic        due, take, guard;
  logic        int_off, int_fs, host_allow;
  logic [DATA_W-1:0] int_data;

  assign req_mode  = mode_e'(mode_i);
  assign illegal   = mode_wr_i && (req_mode == M_IFS) && gain_max_i;
  assign mw_ok     = mode_wr_i && !illegal;
  assign factory   = mw_ok && (req_mode == M_IFS) && gain_one_i && int_ref_i;
  assign new_runs  = mw_ok && (req_mode != M_IDLE) && (req_mode != M_PDOWN) && !factory;
  assign conv_mode = running_q && ((mode_q == M_CONT) || (mode_q == M_SINGLE));
  assign re_conv   = !mode_wr_i && conv_mode && (cfg_wr_i || (chan_i != chan_q));
  assign restart   = new_runs || re_conv;

  always_comb begin
    need = 3'd2;
    if (mode_wr_i && (req_mode == M_IFS) && !gain_one_i) need = 3'd4;
  end

  seq_rate_timer #(
    .RATE_W(RATE_W), .PERIOD_W(PERIOD_W), .BASE_CNT(BASE_CNT),
    .GUARD(GUARD), .RST_RATE(RST_RATE)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .run_i(running_q),
    .rate_i(rate_i), .need_i(need), .res_valid_i(res_valid_i),
    .due_o(due), .take_o(take), .guard_o(guard)
  );

  assign int_off    = take && ((mode_q == M_ZS) || (mode_q == M_SOFF));
  assign int_fs     = (take && ((mode_q == M_IFS) || (mode_q == M_SFS))) || fac_pend_q;
  assign int_data   = fac_pend_q ? FACTORY_FS : res_data_i;
  assign host_allow = (mode_q == M_IDLE) || (mode_q == M_PDOWN);

  seq_coef_port #(.DATA_W(DATA_W), .CH_W(CH_W)) u_coef (
    .clk(clk), .rst_n(rst_n), .allow_i(host_allow),
    .int_off_i(int_off), .int_fs_i(int_fs), .int_ch_i(chan_q), .int_data_i(int_data),
    .host_wr_i(host_coef_wr_i), .host_fs_i(host_coef_fs_i),
    .host_ch_i(host_coef_ch_i), .host_data_i(host_coef_data_i),
    .wr_off_o(coef_wr_off_o), .wr_fs_o(coef_wr_fs_o),
    .ch_o(coef_ch_o), .data_o(coef_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_CONT;
      running_q  <= 1'b1;
      rdy_q      <= 1'b1;
      err_q      <= 1'b0;
      data_q     <= '0;
      chan_q     <= '0;
      fac_pend_q <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      chan_q     <= chan_i;
      start_q    <= restart;
      fac_pend_q <= factory;
      if (mw_ok) begin
        mode_q    <= req_mode;
        running_q <= new_runs;
        rdy_q     <= 1'b1;
        if ((req_mode != M_IDLE) && (req_mode != M_PDOWN)) err_q <= 1'b0;
      end else if (fac_pend_q) begin
        mode_q <= M_IDLE;
        rdy_q  <= 1'b0;
      end else if (re_conv) begin
        rdy_q <= 1'b1;
        err_q <= 1'b0;
      end else if (take) begin
        rdy_q <= 1'b0;
        case (mode_q)
          M_CONT: begin
            data_q <= res_data_i;
            err_q  <= res_clamp_i;
          end
          M_SINGLE: begin
            data_q    <= res_data_i;
            err_q     <= res_clamp_i;
            mode_q    <= M_PDOWN;
            running_q <= 1'b0;
          end
          default: begin
            mode_q    <= M_IDLE;
            running_q <= 1'b0;
          end
        endcase
      end else if (rd_data_i || (guard && (mode_q == M_CONT))) begin
        rdy_q <= 1'b1;
      end
    end
  end

  assign res_ready_o  = due;
  assign conv_start_o = start_q;
  assign mod_rst_o    = ~running_q;
  assign pdown_o      = (mode_q == M_PDOWN);
  assign mode_o       = mode_q;
  assign data_o       = data_q;
  assign rdy_o        = rdy_q;
  assign err_o        = err_q;

  // single shot sleeps with ready held low (R3)
  p_single_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && (mode_q == M_SINGLE) && !mode_wr_i |=> (mode_q == M_PDOWN) && !rdy_q);

  // calibrations fall back to idle (R6)
  p_cal_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && mode_q[2] && !mode_wr_i |=> (mode_q == M_IDLE) && !rdy_q);

  // illegal gain calibration request keeps the mode (R9)
  p_illegal_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> mode_q == $past(mode_q));

  // entering power-down raises ready (R5)
  p_pdown_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mw_ok && (req_mode == M_PDOWN) |=> rdy_q && pdown_o);

  // idle and power-down never offer a result (R5)
  p_no_due_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> !res_ready_o);
endmodule

// File: tb/tb_conv_cal_seq.sv
module tb_conv_cal_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int GUARD = 2;
  localparam logic [DW-1:0] FACT = 24'hC3A512;

  typedef struct packed {
    logic [2:0] mode;
    logic       gone;
    logic       iref;
    logic [2:0] nper;
    logic [2:0] fmode;
    logic       off;
    logic       fs;
    logic       clamp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'd0, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 1'b0, 1'b1},
    '{3'd1, 1'b0, 1'b0, 3'd2, 3'd3, 1'b0, 1'b0, 1'b0},
    '{3'd4, 1'b0, 1'b0, 3'd2, 3'd2, 1'b1, 1'b0, 1'b0},
    '{3'd5, 1'b0, 1'b0, 3'd4, 3'd2, 1'b0, 1'b1, 1'b0},
    '{3'd5, 1'b1, 1'b0, 3'd2, 3'd2, 1'b0, 1'b1, 1'b0},
    '{3'd6, 1'b0, 1'b0, 3'd2, 3'd2, 1'b1, 1'b0, 1'b0},
    '{3'd7, 1'b0, 1'b0, 3'd2, 3'd2, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode_i = '0;
  logic mode_wr_i = 0, cfg_wr_i = 0, gain_one_i = 0, gain_max_i = 0, int_ref_i = 0;
  logic [1:0] chan_i = '0;
  logic [3:0] rate_i = 4'd1;
  logic rd_data_i = 0, res_valid_i = 0, res_clamp_i = 0;
  logic [DW-1:0] res_data_i = '0;
  logic host_coef_wr_i = 0, host_coef_fs_i = 0;
  logic [1:0] host_coef_ch_i = '0;
  logic [DW-1:0] host_coef_data_i = '0;
  logic res_ready_o, conv_start_o, mod_rst_o, pdown_o, rdy_o, err_o;
  logic [2:0] mode_o;
  logic [DW-1:0] data_o, coef_data_o;
  logic coef_wr_off_o, coef_wr_fs_o;
  logic [1:0] coef_ch_o;

  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_cal_seq #(.FACTORY_FS(FACT), .GUARD(GUARD)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_wr_i(mode_wr_i),
    .cfg_wr_i(cfg_wr_i), .chan_i(chan_i), .rate_i(rate_i),
    .gain_one_i(gain_one_i), .gain_max_i(gain_max_i), .int_ref_i(int_ref_i),
    .rd_data_i(rd_data_i), .res_valid_i(res_valid_i), .res_ready_o(res_ready_o),
    .res_data_i(res_data_i), .res_clamp_i(res_clamp_i),
    .conv_start_o(conv_start_o), .mod_rst_o(mod_rst_o), .pdown_o(pdown_o),
    .mode_o(mode_o), .data_o(data_o), .rdy_o(rdy_o), .err_o(err_o),
    .host_coef_wr_i(host_coef_wr_i), .host_coef_fs_i(host_coef_fs_i),
    .host_coef_ch_i(host_coef_ch_i), .host_coef_data_i(host_coef_data_i),
    .coef_wr_off_o(coef_wr_off_o), .coef_wr_fs_o(coef_wr_fs_o),
    .coef_ch_o(coef_ch_o), .coef_data_o(coef_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [2:0] m);
    @(negedge clk);
    mode_i = m; mode_wr_i = 1'b1;
    @(negedge clk);
    mode_wr_i = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!res_ready_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic give_result(input logic [DW-1:0] d, input logic c);
    res_valid_i = 1'b1; res_data_i = d; res_clamp_i = c;
    @(negedge clk);
    res_valid_i = 1'b0;
  endtask

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd5: return "R7";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, m;
    logic [DW-1:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset rdy", rdy_o, 1);
    chk("R1 reset err", err_o, 0);
    chk("R1 reset data", data_o, 0);
    chk("R1 reset mode", mode_o, 0);
    chk("R1 reset ready", res_ready_o, 0);
    rst_n = 1'b1;
    wait_ready(n);
    chk("R1 first result two periods", n, 32);
    give_result(24'hABCDEF, 1'b0);
    chk("R1 data loaded", data_o, 24'hABCDEF);
    chk("R1 rdy low after update", rdy_o, 0);
    // R14 valid while nothing due is ignored
    res_valid_i = 1'b1; res_data_i = 24'h0BAD00;
    repeat (3) @(negedge clk);
    res_valid_i = 1'b0;
    chk("R14 early valid ignored", data_o, 24'hABCDEF);
    // R11 guard interval
    n = 0;
    while (!rdy_o && n < 5000) begin @(negedge clk); n++; end
    m = 0;
    while (!res_ready_o && m < 5000) begin @(negedge clk); m++; end
    chk("R11 rdy leads result by guard", m, GUARD);
    give_result(24'h111111, 1'b1);
    chk("R10 err from clamp", err_o, 1);
    // R13 rate change waits for restart
    rate_i = 4'd0;
    wait_ready(n);
    chk("R13 period unchanged before restart", n, 16);
    give_result(24'h222222, 1'b0);
    chk("R10 err follows clamp", err_o, 0);
    // R2 channel change restart
    chan_i = 2'd1;
    @(negedge clk);
    chk("R2 start pulse on channel change", conv_start_o, 1);
    chk("R2 rdy set on restart", rdy_o, 1);
    wait_ready(n);
    chk("R2 R13 two new-rate periods", n, 16);
    give_result(24'h333333, 1'b1);
    chk("R1 continuous data", data_o, 24'h333333);
    cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    chk("R10 err cleared on restart", err_o, 0);
    chk("R2 cfg write start pulse", conv_start_o, 1);
    chk("R2 cfg write rdy", rdy_o, 1);
    // R12 host write outside idle is ignored
    host_coef_wr_i = 1'b1; host_coef_data_i = 24'h777777;
    @(negedge clk);
    host_coef_wr_i = 1'b0;
    chk("R12 no strobe while running", {coef_wr_off_o, coef_wr_fs_o}, 0);
    rate_i = 4'd1;

    for (int i = 0; i < 7; i++) begin
      logic [DW-1:0] d;
      d = 24'h000100 + DW'(i);
      write_mode(3'd2);
      gain_one_i = VECS[i].gone; int_ref_i = VECS[i].iref;
      write_mode(VECS[i].mode);
      wait_ready(n);
      chk({tag_of(VECS[i].mode), " period count"}, n, 32'(VECS[i].nper) * 16);
      give_result(d, VECS[i].clamp);
      chk({tag_of(VECS[i].mode), " final mode"}, mode_o, VECS[i].fmode);
      chk({tag_of(VECS[i].mode), " offset strobe"}, coef_wr_off_o, VECS[i].off);
      chk({tag_of(VECS[i].mode), " full-scale strobe"}, coef_wr_fs_o, VECS[i].fs);
      chk({tag_of(VECS[i].mode), " rdy low"}, rdy_o, 0);
      if (VECS[i].off || VECS[i].fs) begin
        chk({tag_of(VECS[i].mode), " coef data"}, coef_data_o, d);
        chk({tag_of(VECS[i].mode), " coef channel"}, coef_ch_o, 1);
      end else begin
        chk({tag_of(VECS[i].mode), " data"}, data_o, d);
        chk("R10 err per vector", err_o, VECS[i].clamp);
      end
    end

    // R9 illegal internal gain calibration
    gain_one_i = 0; int_ref_i = 0; gain_max_i = 1;
    write_mode(3'd5);
    gain_max_i = 0;
    chk("R9 mode kept", mode_o, 2);
    chk("R9 rdy kept low", rdy_o, 0);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (res_ready_o) n++;
    end
    chk("R5 no result in idle", n, 0);
    chk("R5 modulator held in reset", mod_rst_o, 1);
    // R12 host write in idle
    host_coef_wr_i = 1'b1; host_coef_fs_i = 1'b0; host_coef_ch_i = 2'd2;
    host_coef_data_i = 24'h0C0FFE;
    @(negedge clk);
    host_coef_wr_i = 1'b0;
    chk("R12 host offset strobe", coef_wr_off_o, 1);
    chk("R12 host channel", coef_ch_o, 2);
    chk("R12 host data", coef_data_o, 24'h0C0FFE);
    // R8 stored coefficient
    gain_one_i = 1; int_ref_i = 1;
    write_mode(3'd5);
    chk("R8 rdy high at start", rdy_o, 1);
    @(negedge clk);
    chk("R8 factory strobe", coef_wr_fs_o, 1);
    chk("R8 factory data", coef_data_o, FACT);
    chk("R8 back to idle", mode_o, 2);
    chk("R8 rdy low", rdy_o, 0);
    gain_one_i = 0; int_ref_i = 0;
    // R3 and R4 single shot held then read
    write_mode(3'd1);
    wait_ready(n);
    give_result(24'h444444, 1'b0);
    keep = data_o;
    repeat (50) @(negedge clk);
    chk("R3 rdy stays low unread", rdy_o, 0);
    chk("R3 data kept", data_o, keep);
    chk("R5 pdown flag", pdown_o, 1);
    rd_data_i = 1'b1;
    @(negedge clk);
    rd_data_i = 1'b0;
    chk("R4 read sets rdy", rdy_o, 1);
    write_mode(3'd4);
    wait_ready(n);
    give_result(24'h555555, 1'b0);
    write_mode(3'd3);
    chk("R5 power-down sets rdy", rdy_o, 1);
    chk("R5 power-down flag", pdown_o, 1);
    chk("R5 reset held in power-down", mod_rst_o, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule